// File: doc/BRIEF.md
# Dual Programmable Down-Counter Timers with Watchdog

This block holds two 8-bit down-counters that turn slow timebase strobes into periodic or one-shot events. Each counter picks its timebase from five prescaler strobes (4096 Hz, 64 Hz, 1 Hz, one per minute, one per hour), counts a programmed load value down, and raises a flag when the count is used up. Timer A works either as a repeating countdown or as a one-shot watchdog that must be reloaded by software before it expires. Timer B only repeats. A third source raises a flag on every 1 Hz strobe while it is enabled.

Each event drives an active-high interrupt line. In held mode the line follows the event flags until they are cleared. In pulse mode the line goes high for a fixed number of 8192 Hz strobes that depends on the timebase: 1 strobe (about 122 µs) for the 4096 Hz source, 64 strobes (about 7.8 ms) for 64 Hz, and 128 strobes (about 15.6 ms) for the slower sources and the seconds event. The period of a timer is its load value divided by the source frequency.

Top module: `tmr_cdwd_top`

## Requirements
- R1: After reset every flag and every interrupt output is 0, both load values are 0 and Timer A is off.
- R2: A counter steps only on the strobe of its selected source; source codes are 0 = 4096 Hz (bit 0 of `src_tick`), 1 = 64 Hz (bit 1), 2 = 1 Hz (bit 2), 3 = per minute (bit 3), 4 = per hour (bit 4); codes 5 to 7 never step the counter.
- R3: With load value n in 1..255 in a repeating mode, the flag is set in the cycle after the n-th selected strobe, the count restarts from n, and n further strobes set it again.
- R4: Timer A mode code 1 is repeating countdown (sets `flag_cd_a`), code 2 is watchdog (sets `flag_wd_a` once and then stays stopped until reloaded), codes 0 and 3 stop Timer A.
- R5: `clr_cd_a` clears only `flag_cd_a`, `clr_wd_a` clears only `flag_wd_a`, `clr_b` clears `flag_b`, `clr_sec` clears `flag_sec`; an expiry in the same cycle as a clear leaves the flag set.
- R6: A load value of 0 keeps the counter idle and never sets a flag.
- R7: A write to a value register, or any configuration write, restarts that counter from its load value, so the flag comes n selected strobes after the write.
- R8: With `cfg_pulse` = 0, `irq_a` equals `flag_cd_a` OR `flag_wd_a`, `irq_b` equals `flag_b` and `irq_sec` equals `flag_sec`.
- R9: With `cfg_pulse` = 1, an interrupt rises in the cycle after the expiry and stays high for exactly 1, 64 or 128 `tick_8k` strobes for sources 4096 Hz, 64 Hz and slower respectively; the flags still set.
- R10: With `cfg_sec_en` = 1 each 1 Hz strobe sets `flag_sec` (pulse width 128 in pulse mode); with it 0 the strobe has no effect.
- R11: With `cfg_b_en` = 0 Timer B does not count and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 5 | One-cycle timebase strobes, bit i for source code i |
| tick_8k | input | 1 | 8192 Hz strobe that times interrupt pulses |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_a_mode | input | 2 | Timer A mode code |
| cfg_a_src | input | 3 | Timer A source code |
| cfg_b_en | input | 1 | Timer B enable |
| cfg_b_src | input | 3 | Timer B source code |
| cfg_pulse | input | 1 | 1 = pulsed interrupts, 0 = held |
| cfg_sec_en | input | 1 | Seconds event enable |
| val_a_we | input | 1 | Timer A load value write strobe |
| val_b_we | input | 1 | Timer B load value write strobe |
| val_wdata | input | 8 | Load value written by either strobe |
| clr_cd_a | input | 1 | Clear Timer A countdown flag |
| clr_wd_a | input | 1 | Clear Timer A watchdog flag |
| clr_b | input | 1 | Clear Timer B flag |
| clr_sec | input | 1 | Clear seconds flag |
| flag_cd_a | output | 1 | Timer A countdown expired |
| flag_wd_a | output | 1 | Timer A watchdog expired |
| flag_b | output | 1 | Timer B expired |
| flag_sec | output | 1 | Seconds event |
| irq_a | output | 1 | Timer A interrupt |
| irq_b | output | 1 | Timer B interrupt |
| irq_sec | output | 1 | Seconds interrupt |

## Verification
Every result is registered once: a flag, a held interrupt and the rising edge of a pulsed interrupt all appear one cycle after the strobe, write or clear that caused them, and a pulse falls one cycle after its last counted `tick_8k` strobe. The bench drives each stimulus for exactly one cycle from the falling edge and samples at the next falling edge, so every check lands in the first cycle the result is due. Periods are checked by strobe count rather than by time: a check after n-1 strobes expects no flag and a check after the n-th expects it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W   = 8;
    localparam int NUM_SRC = 5;
    localparam int PW_W    = 8;

    localparam logic [PW_W-1:0] PW_FAST = PW_W'(1);
    localparam logic [PW_W-1:0] PW_MID  = PW_W'(64);
    localparam logic [PW_W-1:0] PW_SLOW = PW_W'(128);

    typedef enum logic [2:0] {
        SRC_4096 = 3'd0,
        SRC_64   = 3'd1,
        SRC_1HZ  = 3'd2,
        SRC_MIN  = 3'd3,
        SRC_HOUR = 3'd4
    } src_e;

    typedef enum logic [1:0] {
        AM_OFF0 = 2'b00,
        AM_CD   = 2'b01,
        AM_WD   = 2'b10,
        AM_OFF3 = 2'b11
    } amode_e;

    typedef struct packed {
        amode_e     a_mode;
        logic [2:0] a_src;
        logic       b_en;
        logic [2:0] b_src;
        logic       pulse;
        logic       sec_en;
    } cfg_t;

    function automatic logic pick_tick(input logic [NUM_SRC-1:0] ticks,
                                       input logic [2:0] code);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_SRC; i++)
            if (code == 3'(i)) hit = ticks[i];
        return hit;
    endfunction

    function automatic logic [PW_W-1:0] pulse_len(input logic [2:0] code);
        case (code)
            SRC_4096: return PW_FAST;
            SRC_64:   return PW_MID;
            default:  return PW_SLOW;
        endcase
    endfunction

endpackage

// File: rtl/tmr_down.sv
module tmr_down #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         auto_rl,
    input  logic         restart,
    input  logic         ld_we,
    input  logic [W-1:0] ld_val,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] rval_q;

    assign expire = run && tick && (cnt_q == W'(1)) && !ld_we && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            rval_q <= '0;
        end else if (ld_we) begin
            rval_q <= ld_val;
            cnt_q  <= ld_val;
        end else if (restart) begin
            cnt_q <= rval_q;
        end else if (run && tick && cnt_q != '0) begin
            if (cnt_q == W'(1)) cnt_q <= auto_rl ? rval_q : '0;
            else                cnt_q <= cnt_q - W'(1);
        end
    end

    // R3: a repeating expiry restarts from the load value
    a_r3_reload_val: assert property (@(posedge clk) disable iff (rst)
        (expire && auto_rl) |=> cnt_q == $past(rval_q));

    // R4: a watchdog expiry halts the counter
    a_r4_wd_halt: assert property (@(posedge clk) disable iff (rst)
        (expire && !auto_rl) |=> cnt_q == '0);

    // R6: an empty counter stays empty without a reload
    a_r6_zero_idle: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !ld_we && !restart) |=> cnt_q == '0);

endmodule

// File: rtl/tmr_pulse.sv
module tmr_pulse #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig,
    input  logic [PW-1:0] width,
    input  logic          tick_8k,
    output logic          active
);
    logic [PW-1:0] left_q;

    assign active = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst)                       left_q <= '0;
        else if (trig)                 left_q <= width;
        else if (tick_8k && active)    left_q <= left_q - PW'(1);
    end

    // R9: a running pulse keeps its remaining length between strobes
    a_r9_pulse_hold: assert property (@(posedge clk) disable iff (rst)
        (active && !trig && !tick_8k) |=> $stable(left_q));

    // R9: a trigger starts a pulse of the requested length
    a_r9_pulse_start: assert property (@(posedge clk) disable iff (rst)
        trig |=> left_q == $past(width));

endmodule

// File: rtl/tmr_cdwd_top.sv
module tmr_cdwd_top
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               tick_8k,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_a_mode,
    input  logic [2:0]         cfg_a_src,
    input  logic               cfg_b_en,
    input  logic [2:0]         cfg_b_src,
    input  logic               cfg_pulse,
    input  logic               cfg_sec_en,
    input  logic               val_a_we,
    input  logic               val_b_we,
    input  logic [CNT_W-1:0]   val_wdata,
    input  logic               clr_cd_a,
    input  logic               clr_wd_a,
    input  logic               clr_b,
    input  logic               clr_sec,
    output logic               flag_cd_a,
    output logic               flag_wd_a,
    output logic               flag_b,
    output logic               flag_sec,
    output logic               irq_a,
    output logic               irq_b,
    output logic               irq_sec
);
    cfg_t cfg_q;
    logic run_a, rl_a, exp_a, exp_b, exp_sec;
    logic pa, pb, ps;
    logic fcd_q, fwd_q, fb_q, fs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{a_mode: AM_OFF0, a_src: 3'd0, b_en: 1'b0, b_src: 3'd0,
                       pulse: 1'b0, sec_en: 1'b0};
        end else if (cfg_we) begin
            cfg_q <= '{a_mode: amode_e'(cfg_a_mode), a_src: cfg_a_src,
                       b_en: cfg_b_en, b_src: cfg_b_src,
                       pulse: cfg_pulse, sec_en: cfg_sec_en};
        end
    end

    assign run_a   = (cfg_q.a_mode == AM_CD) || (cfg_q.a_mode == AM_WD);
    assign rl_a    = (cfg_q.a_mode == AM_CD);
    assign exp_sec = cfg_q.sec_en && src_tick[SRC_1HZ];

    tmr_down #(.W(CNT_W)) u_cnt_a (
        .clk(clk), .rst(rst), .run(run_a),
        .tick(pick_tick(src_tick, cfg_q.a_src)), .auto_rl(rl_a),
        .restart(cfg_we), .ld_we(val_a_we), .ld_val(val_wdata), .expire(exp_a)
    );

    tmr_down #(.W(CNT_W)) u_cnt_b (
        .clk(clk), .rst(rst), .run(cfg_q.b_en),
        .tick(pick_tick(src_tick, cfg_q.b_src)), .auto_rl(1'b1),
        .restart(cfg_we), .ld_we(val_b_we), .ld_val(val_wdata), .expire(exp_b)
    );

    tmr_pulse #(.PW(PW_W)) u_pls_a (
        .clk(clk), .rst(rst), .trig(exp_a), .width(pulse_len(cfg_q.a_src)),
        .tick_8k(tick_8k), .active(pa)
    );

    tmr_pulse #(.PW(PW_W)) u_pls_b (
        .clk(clk), .rst(rst), .trig(exp_b), .width(pulse_len(cfg_q.b_src)),
        .tick_8k(tick_8k), .active(pb)
    );

    tmr_pulse #(.PW(PW_W)) u_pls_s (
        .clk(clk), .rst(rst), .trig(exp_sec), .width(PW_SLOW),
        .tick_8k(tick_8k), .active(ps)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fcd_q <= 1'b0;
            fwd_q <= 1'b0;
            fb_q  <= 1'b0;
            fs_q  <= 1'b0;
        end else begin
            if (exp_a && rl_a)      fcd_q <= 1'b1;
            else if (clr_cd_a)      fcd_q <= 1'b0;
            if (exp_a && !rl_a)     fwd_q <= 1'b1;
            else if (clr_wd_a)      fwd_q <= 1'b0;
            if (exp_b)              fb_q  <= 1'b1;
            else if (clr_b)         fb_q  <= 1'b0;
            if (exp_sec)            fs_q  <= 1'b1;
            else if (clr_sec)       fs_q  <= 1'b0;
        end
    end

    assign flag_cd_a = fcd_q;
    assign flag_wd_a = fwd_q;
    assign flag_b    = fb_q;
    assign flag_sec  = fs_q;
    assign irq_a     = cfg_q.pulse ? pa : (fcd_q || fwd_q);
    assign irq_b     = cfg_q.pulse ? pb : fb_q;
    assign irq_sec   = cfg_q.pulse ? ps : fs_q;

    // R3: the Timer B flag only rises on a counter expiry
    a_r3_flag_b_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(fb_q) |-> $past(exp_b));

    // R5: a watchdog clear with no competing expiry drops the flag
    a_r5_wd_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_wd_a && !exp_a) |=> !fwd_q);

    // R11: a disabled Timer B never expires
    a_r11_b_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.b_en |-> !exp_b);

    // R10: the seconds flag rises only on an enabled 1 Hz strobe
    a_r10_sec_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(fs_q) |-> $past(exp_sec));

endmodule

// File: tb/tmr_cdwd_top_tb_top.sv
module tmr_cdwd_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] src_tick = '0;
    logic       tick_8k = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_a_mode = 2'b00;
    logic [2:0] cfg_a_src = 3'd0;
    logic       cfg_b_en = 1'b0;
    logic [2:0] cfg_b_src = 3'd0;
    logic       cfg_pulse = 1'b0;
    logic       cfg_sec_en = 1'b0;
    logic       val_a_we = 1'b0, val_b_we = 1'b0;
    logic [7:0] val_wdata = '0;
    logic       clr_cd_a = 1'b0, clr_wd_a = 1'b0, clr_b = 1'b0, clr_sec = 1'b0;
    logic       flag_cd_a, flag_wd_a, flag_b, flag_sec, irq_a, irq_b, irq_sec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_cdwd_top dut_i (.*);

    function automatic int exp_width(input int src);
        if (src == 0) return 1;
        if (src == 1) return 64;
        return 128;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input int idx);
        src_tick = 5'(1) << idx;
        @(negedge clk);
        src_tick = '0;
    endtask

    task automatic strobes(input int idx, input int n);
        for (int i = 0; i < n; i++) strobe(idx);
    endtask

    task automatic t8(input int n);
        for (int i = 0; i < n; i++) begin
            tick_8k = 1'b1;
            @(negedge clk);
            tick_8k = 1'b0;
        end
    endtask

    task automatic wcfg(input int am, input int as, input bit be, input int bs,
                        input bit pm, input bit se);
        cfg_a_mode = 2'(am); cfg_a_src = 3'(as); cfg_b_en = be;
        cfg_b_src = 3'(bs); cfg_pulse = pm; cfg_sec_en = se;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wval(input bit is_a, input int v);
        val_wdata = 8'(v);
        if (is_a) val_a_we = 1'b1; else val_b_we = 1'b1;
        @(negedge clk);
        val_a_we = 1'b0; val_b_we = 1'b0;
    endtask

    task automatic clear_all();
        clr_cd_a = 1'b1; clr_wd_a = 1'b1; clr_b = 1'b1; clr_sec = 1'b1;
        @(negedge clk);
        clr_cd_a = 1'b0; clr_wd_a = 1'b0; clr_b = 1'b0; clr_sec = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, s, o;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", {flag_cd_a, flag_wd_a, flag_b, flag_sec}, 0);
        chk("R1 irqs", {irq_a, irq_b, irq_sec}, 0);
        strobes(0, 3);
        chk("R1 timer A off after reset", flag_cd_a | flag_wd_a, 0);

        // R2 R3 R8: random Timer B periods and sources
        for (int it = 0; it < 6; it++) begin
            n = $urandom_range(1, 8);
            s = $urandom_range(0, 4);
            o = (s + 1) % 5;
            wcfg(0, 0, 1'b1, s, 1'b0, 1'b0);
            wval(1'b0, n);
            clear_all();
            strobes(s, n - 1);
            strobe(o);
            chk("R2 other source ignored", flag_b, 0);
            strobe(s);
            chk("R3 flag after n strobes", flag_b, 1);
            chk("R8 held irq_b follows flag", irq_b, 1);
            clr_b = 1'b1; @(negedge clk); clr_b = 1'b0;
            chk("R5 clr_b clears flag", flag_b, 0);
            chk("R8 held irq_b drops", irq_b, 0);
            strobes(s, n - 1);
            chk("R3 no flag before reload period", flag_b, 0);
            strobe(s);
            chk("R3 reload period", flag_b, 1);
        end

        // R2 invalid source codes
        wcfg(0, 0, 1'b1, 5, 1'b0, 1'b0);
        wval(1'b0, 1);
        clear_all();
        for (int k = 0; k < 5; k++) strobe(k);
        chk("R2 code 5 never counts", flag_b, 0);

        // R11 Timer B disabled
        wcfg(0, 0, 1'b0, 0, 1'b0, 1'b0);
        strobes(0, 4);
        chk("R11 disabled B", flag_b, 0);

        // R6 zero load
        wcfg(0, 0, 1'b1, 0, 1'b0, 1'b0);
        wval(1'b0, 0);
        strobes(0, 20);
        chk("R6 zero load idle", flag_b, 0);

        // R5 set wins over clear
        wval(1'b0, 1);
        strobe(0);
        chk("R5 flag set n=1", flag_b, 1);
        src_tick = 5'b00001; clr_b = 1'b1;
        @(negedge clk);
        src_tick = '0; clr_b = 1'b0;
        chk("R5 expiry beats clear", flag_b, 1);
        clr_b = 1'b1; @(negedge clk); clr_b = 1'b0;
        chk("R5 clear alone", flag_b, 0);

        // R7 restart on value write and on config write
        wcfg(0, 0, 1'b1, 2, 1'b0, 1'b0);
        wval(1'b0, 5);
        strobes(2, 3);
        wval(1'b0, 4);
        strobes(2, 3);
        chk("R7 new value restarts count", flag_b, 0);
        strobe(2);
        chk("R7 flag at new value", flag_b, 1);
        clear_all();
        strobes(2, 2);
        wcfg(0, 0, 1'b1, 2, 1'b0, 1'b0);
        strobes(2, 3);
        chk("R7 config write restarts", flag_b, 0);
        strobe(2);
        chk("R7 flag after config restart", flag_b, 1);

        // R4 Timer A countdown
        wcfg(1, 3, 1'b0, 0, 1'b0, 1'b0);
        wval(1'b1, 3);
        clear_all();
        strobes(3, 3);
        chk("R4 countdown sets cd flag", flag_cd_a, 1);
        chk("R4 countdown leaves wd flag", flag_wd_a, 0);
        chk("R8 irq_a held", irq_a, 1);

        // R4 R5 watchdog
        n = $urandom_range(2, 6);
        wcfg(2, 4, 1'b0, 0, 1'b0, 1'b0);
        wval(1'b1, n);
        clear_all();
        strobes(4, n - 1);
        chk("R4 watchdog before expiry", flag_wd_a, 0);
        strobe(4);
        chk("R4 watchdog flag", flag_wd_a, 1);
        chk("R4 watchdog no cd flag", flag_cd_a, 0);
        clr_cd_a = 1'b1; @(negedge clk); clr_cd_a = 1'b0;
        chk("R5 cd clear keeps wd", flag_wd_a, 1);
        clr_wd_a = 1'b1; @(negedge clk); clr_wd_a = 1'b0;
        chk("R5 wd clear", flag_wd_a, 0);
        strobes(4, n + 2);
        chk("R4 watchdog stays stopped", flag_wd_a, 0);
        wval(1'b1, 1);
        strobe(4);
        chk("R4 watchdog rearmed by reload", flag_wd_a, 1);

        // R4 mode 3 is off
        wcfg(3, 0, 1'b0, 0, 1'b0, 1'b0);
        wval(1'b1, 1);
        clear_all();
        strobes(0, 4);
        chk("R4 mode 3 off", flag_cd_a | flag_wd_a, 0);

        // R9 pulse widths per source
        for (int ps = 0; ps < 4; ps++) begin
            wcfg(0, 0, 1'b1, ps, 1'b1, 1'b0);
            wval(1'b0, 1);
            clear_all();
            strobe(ps);
            chk("R9 pulse rises", irq_b, 1);
            chk("R9 flag set in pulse mode", flag_b, 1);
            t8(exp_width(ps) - 1);
            chk("R9 pulse still high", irq_b, 1);
            t8(1);
            chk("R9 pulse ends", irq_b, 0);
        end

        // R9 timer A pulse at 64 Hz
        wcfg(1, 1, 1'b0, 0, 1'b1, 1'b0);
        wval(1'b1, 2);
        strobes(1, 2);
        chk("R9 irq_a pulse rises", irq_a, 1);
        t8(64);
        chk("R9 irq_a pulse ends", irq_a, 0);

        // R10 seconds event
        wcfg(0, 0, 1'b0, 0, 1'b0, 1'b0);
        clear_all();
        strobe(2);
        chk("R10 disabled seconds", flag_sec, 0);
        wcfg(0, 0, 1'b0, 0, 1'b0, 1'b1);
        strobe(2);
        chk("R10 seconds flag", flag_sec, 1);
        chk("R8 irq_sec held", irq_sec, 1);
        clr_sec = 1'b1; @(negedge clk); clr_sec = 1'b0;
        chk("R5 clr_sec", flag_sec, 0);
        wcfg(0, 0, 1'b0, 0, 1'b1, 1'b1);
        strobe(2);
        t8(127);
        chk("R10 seconds pulse high", irq_sec, 1);
        t8(1);
        chk("R10 seconds pulse width", irq_sec, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule